// File: doc/BRIEF.md
# Linked-List DMA Channel

This block is one DMA channel that copies data element by element while walking a chain of descriptors kept in memory. Software loads the first descriptor through a small register interface and sets the enable bit. The channel then waits for a peripheral request. It reads each element from the source address and writes it to the destination address over a single word-wide memory master port. When a descriptor is finished it either stops or fetches the next descriptor through that same port.

A descriptor is four consecutive 32-bit words. Each pointer points at the first word of the next one. Two flow-control modes are offered. In controller mode, the count field of the control word decides when a descriptor ends. In peripheral mode, the count is ignored and the peripheral marks the final request with one of its "last" inputs. A sticky terminal-count flag drives the interrupt output at the end of every descriptor that asks for it.

Top module: `lldma_channel`

## Requirements
- R1: After reset, the status register (index 5) and the remaining-count register (index 6) read 0, `tc_irq` is low and `mem_req` is low.
- R2: A descriptor is fetched as four reads at the next pointer with bit 0 cleared, in this order: source, destination, next pointer, control word (offsets 0, 4, 8, 12). `mem_bus` equals bit 0 of that pointer during each of these reads.
- R3: The control word fields are count [11:0], source burst [14:12], destination burst [17:15], source width [20:18], destination width [23:21], source bus [24], destination bus [25], source increment [26], destination increment [27] and interrupt enable [31]. In controller mode a descriptor moves exactly `count` elements and writes nothing past them.
- R4: When a descriptor ends and bits [31:1] of its next pointer are zero, the channel clears its enable bit and returns to idle. Status bit 0 (enable) and bit 1 (active) then both read 0.
- R5: At the end of a descriptor whose interrupt-enable bit is set, a sticky flag is set. It drives `tc_irq` and reads as status bit 2. Writing 1 to bit 0 of register index 5 clears it.
- R6: In controller mode, a single request moves one element. A burst request moves the smaller of the remaining count and the burst length, where the source burst code k gives 1 element for k=0 and 2^(k+1) elements otherwise. `preq_done` pulses for one cycle after the last write of each serviced request.
- R7: In controller mode, the last-burst and last-single inputs on their own start no transfer and leave the remaining count unchanged.
- R8: In peripheral mode (config bit 1 = 1), the count field is ignored. A burst or last-burst request moves a full burst, a single or last-single request moves one element, and the descriptor ends after servicing a request flagged as last.
- R9: Width code 0 means 1 byte, 1 means 2 bytes and 2 means 4 bytes. After each element, an address with its increment bit set advances by its own width in bytes. An address with the bit clear stays fixed.
- R10: Register index 6 returns the remaining element count of the active descriptor. It is loaded from the count field and decreases by one after each written element, stopping at 0.
- R11: The register indices are 0 source, 1 destination, 2 next, 3 control and 4 config (bit 0 enable, bit 1 flow mode). While the channel is active, writes to indices 0 to 4 have no effect.
- R12: In controller mode, a descriptor with count 0 moves no data and goes straight to its end-of-descriptor handling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | AW | Byte address of the access |
| mem_size | output | 2 | Access width code: 0 byte, 1 half, 2 word |
| mem_bus | output | 1 | Selected bus master for the access |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access completes in this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| preq_burst | input | 1 | Peripheral burst request |
| preq_single | input | 1 | Peripheral single request |
| preq_last_burst | input | 1 | Peripheral final burst request |
| preq_last_single | input | 1 | Peripheral final single request |
| preq_done | output | 1 | One-cycle pulse when a request has been serviced |
| tc_irq | output | 1 | Terminal-count interrupt (sticky) |

## Verification
The hardest situation to reach is a long descriptor chain in which each descriptor uses a different burst length and count. Requests then arrive while the channel is still fetching the next descriptor, and the last grant of one descriptor has to be cut short by the remaining count. The stimulus builds random three-descriptor chains in memory, with bus bits alternating across the chain, and serves the channel with a random mix of burst and single requests until the expected element total has been written. A memory model with random acknowledge delays checks the address and bus of every fetch. Directed runs cover the cases that random chains rarely produce: a zero count, the last inputs used in controller mode, register writes during a transfer, and peripheral mode running past the programmed count.

// File: rtl/lldma_pkg.sv
package lldma_pkg;

  localparam int CNT_W = 12;

  localparam logic [2:0] REG_SRC  = 3'd0;
  localparam logic [2:0] REG_DST  = 3'd1;
  localparam logic [2:0] REG_NEXT = 3'd2;
  localparam logic [2:0] REG_CTRL = 3'd3;
  localparam logic [2:0] REG_CFG  = 3'd4;
  localparam logic [2:0] REG_STAT = 3'd5;
  localparam logic [2:0] REG_REM  = 3'd6;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_READ,
    ST_WRITE,
    ST_ENDD,
    ST_FETCH
  } ch_state_e;

  typedef struct packed {
    logic             tc_ie;
    logic [2:0]       rsvd;
    logic             dst_inc;
    logic             src_inc;
    logic             dst_bus;
    logic             src_bus;
    logic [2:0]       dwidth;
    logic [2:0]       swidth;
    logic [2:0]       dburst;
    logic [2:0]       sburst;
    logic [CNT_W-1:0] count;
  } ctrl_t;

  // elements per burst for a burst code
  function automatic logic [8:0] burst_elems(input logic [2:0] code);
    burst_elems = (code == 3'd0) ? 9'd1 : (9'd2 << code);
  endfunction

  // bytes per element for a width code
  function automatic logic [2:0] width_bytes(input logic [2:0] code);
    case (code)
      3'd0:    width_bytes = 3'd1;
      3'd1:    width_bytes = 3'd2;
      default: width_bytes = 3'd4;
    endcase
  endfunction

  // bus size code for a width code
  function automatic logic [1:0] size_code(input logic [2:0] code);
    size_code = (code >= 3'd2) ? 2'd2 : code[1:0];
  endfunction

endpackage

// File: rtl/lldma_addr_gen.sv
module lldma_addr_gen
  import lldma_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          step,
  input  logic          inc,
  input  logic [2:0]    width,
  output logic [AW-1:0] addr
);

  logic [AW-1:0] stride;
  assign stride = AW'(width_bytes(width));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          addr <= '0;
    else if (load)       addr <= load_val;
    else if (step && inc) addr <= addr + stride;
  end

  // fixed addresses never move on a step
  p_fixed_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !inc && !load) |=> $stable(addr));

  // incrementing addresses advance by the element width
  p_step_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (step && inc && !load) |=> (addr == $past(addr) + $past(stride)));

endmodule

// File: rtl/lldma_grant.sv
module lldma_grant
  import lldma_pkg::*;
#(
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          periph_mode,
  input  logic          breq,
  input  logic          sreq,
  input  logic          lbreq,
  input  logic          lsreq,
  input  logic [2:0]    burst_code,
  input  logic [CW-1:0] remaining,
  output logic          go,
  output logic [8:0]    beats,
  output logic          last
);

  logic [8:0] blen;
  assign blen = burst_elems(burst_code);

  always_comb begin
    go    = 1'b0;
    beats = 9'd1;
    last  = 1'b0;
    if (!periph_mode) begin
      go = breq || sreq;
      if (breq) beats = (32'(remaining) < 32'(blen)) ? 9'(remaining) : blen;
    end else begin
      go    = breq || sreq || lbreq || lsreq;
      beats = (breq || lbreq) ? blen : 9'd1;
      last  = lbreq || lsreq;
    end
  end

  // controller grants never overrun the remaining count
  p_beats_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !periph_mode && remaining != '0) |-> (beats != 9'd0 && 32'(beats) <= 32'(remaining)));

  // last inputs alone never open a controller grant
  p_last_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!periph_mode && !breq && !sreq) |-> !go);

endmodule

// File: rtl/lldma_channel.sv
module lldma_channel
  import lldma_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [2:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [1:0]    mem_size,
  output logic          mem_bus,
  output logic [31:0]   mem_wdata,
  input  logic          mem_ack,
  input  logic [31:0]   mem_rdata,
  input  logic          preq_burst,
  input  logic          preq_single,
  input  logic          preq_last_burst,
  input  logic          preq_last_single,
  output logic          preq_done,
  output logic          tc_irq
);

  ch_state_e        state_q;
  logic             en_q, periph_q, tc_q, done_q, last_q;
  ctrl_t            ctrl_q;
  logic [31:0]      next_q, next_new_q, data_q;
  logic [CNT_W-1:0] rem_q;
  logic [8:0]       beats_q;
  logic [1:0]       fidx_q;
  logic [AW-1:0]    src_addr, dst_addr;

  // named internal events
  logic idle, wr_ok, rd_done, wr_done, fetch_done, zero_cnt, take;
  logic burst_end, desc_end, chain_end, tc_clr;
  logic grant_go, grant_last;
  logic [8:0] grant_beats;

  assign idle       = (state_q == ST_IDLE);
  assign wr_ok      = reg_we && idle;
  assign rd_done    = (state_q == ST_READ)  && mem_ack;
  assign wr_done    = (state_q == ST_WRITE) && mem_ack;
  assign fetch_done = (state_q == ST_FETCH) && mem_ack;
  assign zero_cnt   = !periph_q && (rem_q == '0);
  assign take       = (state_q == ST_WAIT) && !done_q && !zero_cnt && grant_go;
  assign burst_end  = wr_done && (beats_q == 9'd1);
  assign desc_end   = burst_end && (periph_q ? last_q : (rem_q == CNT_W'(1)));
  assign chain_end  = (state_q == ST_ENDD) && (next_q[31:1] == 31'd0);
  assign tc_clr     = reg_we && (reg_addr == REG_STAT) && reg_wdata[0];

  lldma_grant #(.CW(CNT_W)) u_grant (
    .clk         (clk),
    .rst_n       (rst_n),
    .periph_mode (periph_q),
    .breq        (preq_burst),
    .sreq        (preq_single),
    .lbreq       (preq_last_burst),
    .lsreq       (preq_last_single),
    .burst_code  (ctrl_q.sburst),
    .remaining   (rem_q),
    .go          (grant_go),
    .beats       (grant_beats),
    .last        (grant_last)
  );

  logic [AW-1:0] load_val;
  logic          src_load, dst_load;
  assign load_val = idle ? reg_wdata[AW-1:0] : mem_rdata[AW-1:0];
  assign src_load = (wr_ok && reg_addr == REG_SRC) || (fetch_done && fidx_q == 2'd0);
  assign dst_load = (wr_ok && reg_addr == REG_DST) || (fetch_done && fidx_q == 2'd1);

  lldma_addr_gen #(.AW(AW)) u_src_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (src_load),
    .load_val (load_val),
    .step     (wr_done),
    .inc      (ctrl_q.src_inc),
    .width    (ctrl_q.swidth),
    .addr     (src_addr)
  );

  lldma_addr_gen #(.AW(AW)) u_dst_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (dst_load),
    .load_val (load_val),
    .step     (wr_done),
    .inc      (ctrl_q.dst_inc),
    .width    (ctrl_q.dwidth),
    .addr     (dst_addr)
  );

  // descriptor registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q     <= '0;
      next_q     <= '0;
      next_new_q <= '0;
      rem_q      <= '0;
    end else begin
      if (wr_ok && reg_addr == REG_NEXT) next_q <= reg_wdata;
      if (fetch_done && fidx_q == 2'd2)  next_new_q <= mem_rdata;
      if (fetch_done && fidx_q == 2'd3) begin
        next_q <= next_new_q;
        ctrl_q <= ctrl_t'(mem_rdata);
      end else if (wr_ok && reg_addr == REG_CTRL) begin
        ctrl_q <= ctrl_t'(reg_wdata);
      end
      if (wr_ok && reg_addr == REG_CTRL)        rem_q <= reg_wdata[CNT_W-1:0];
      else if (fetch_done && fidx_q == 2'd3)    rem_q <= mem_rdata[CNT_W-1:0];
      else if (wr_done && rem_q != '0)          rem_q <= rem_q - CNT_W'(1);
    end
  end

  // enable, mode and terminal-count flag
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      periph_q <= 1'b0;
      tc_q     <= 1'b0;
    end else begin
      if (wr_ok && reg_addr == REG_CFG) begin
        en_q     <= reg_wdata[0];
        periph_q <= reg_wdata[1];
      end else if (chain_end) begin
        en_q <= 1'b0;
      end
      if (state_q == ST_ENDD && ctrl_q.tc_ie) tc_q <= 1'b1;
      else if (tc_clr)                        tc_q <= 1'b0;
    end
  end

  // channel sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      beats_q <= '0;
      last_q  <= 1'b0;
      fidx_q  <= '0;
      data_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (en_q) state_q <= ST_WAIT;
        ST_WAIT: begin
          if (zero_cnt) begin
            state_q <= ST_ENDD;
          end else if (take) begin
            beats_q <= grant_beats;
            last_q  <= grant_last;
            state_q <= ST_READ;
          end
        end
        ST_READ: if (rd_done) begin
          data_q  <= mem_rdata;
          state_q <= ST_WRITE;
        end
        ST_WRITE: if (wr_done) begin
          beats_q <= beats_q - 9'd1;
          if (burst_end) done_q <= 1'b1;
          if (desc_end)       state_q <= ST_ENDD;
          else if (burst_end) state_q <= ST_WAIT;
          else                state_q <= ST_READ;
        end
        ST_ENDD: begin
          fidx_q  <= '0;
          state_q <= chain_end ? ST_IDLE : ST_FETCH;
        end
        ST_FETCH: if (fetch_done) begin
          fidx_q <= fidx_q + 2'd1;
          if (fidx_q == 2'd3) state_q <= ST_WAIT;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // memory master drive
  logic [AW-1:0] fetch_addr;
  assign fetch_addr = (next_q[AW-1:0] & ~AW'(1)) + AW'({fidx_q, 2'b00});

  always_comb begin
    mem_req  = 1'b0;
    mem_we   = 1'b0;
    mem_addr = '0;
    mem_size = 2'd2;
    mem_bus  = 1'b0;
    case (state_q)
      ST_READ: begin
        mem_req  = 1'b1;
        mem_addr = src_addr;
        mem_size = size_code(ctrl_q.swidth);
        mem_bus  = ctrl_q.src_bus;
      end
      ST_WRITE: begin
        mem_req  = 1'b1;
        mem_we   = 1'b1;
        mem_addr = dst_addr;
        mem_size = size_code(ctrl_q.dwidth);
        mem_bus  = ctrl_q.dst_bus;
      end
      ST_FETCH: begin
        mem_req  = 1'b1;
        mem_addr = fetch_addr;
        mem_bus  = next_q[0];
      end
      default: ;
    endcase
  end

  assign mem_wdata = data_q;
  assign preq_done = done_q;
  assign tc_irq    = tc_q;

  always_comb begin
    case (reg_addr)
      REG_SRC:  reg_rdata = 32'(src_addr);
      REG_DST:  reg_rdata = 32'(dst_addr);
      REG_NEXT: reg_rdata = next_q;
      REG_CTRL: reg_rdata = ctrl_q;
      REG_CFG:  reg_rdata = {30'd0, periph_q, en_q};
      REG_STAT: reg_rdata = {29'd0, tc_q, !idle, en_q};
      REG_REM:  reg_rdata = 32'(rem_q);
      default:  reg_rdata = '0;
    endcase
  end

  logic unused_bits;
  assign unused_bits = ^{ctrl_q.rsvd, ctrl_q.dburst};

  // an access stays presented until acknowledged
  p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // end of chain drops enable and returns to idle
  p_end_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    chain_end |=> (state_q == ST_IDLE && !en_q));

  // terminal-count flag holds until cleared
  p_tc_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_q && !tc_clr) |=> tc_q);

  // controller mode ignores last-only requests
  p_no_grant_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && !periph_q && !preq_burst && !preq_single) |=> (state_q != ST_READ));

  // remaining count steps down by one per written element
  p_rem_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_done && rem_q != '0) |=> (rem_q == $past(rem_q) - CNT_W'(1)));

  // no register write lands while the channel is active
  p_locked_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && !idle && reg_addr == REG_CFG) |=> (periph_q == $past(periph_q)));

endmodule

// File: tb/lldma_channel_tb.sv
module lldma_channel_tb;
  import lldma_pkg::*;

  logic        clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n;
  logic        reg_we;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        mem_req, mem_we, mem_bus, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [1:0]  mem_size;
  logic        preq_burst, preq_single, preq_last_burst, preq_last_single;
  logic        preq_done, tc_irq;

  int total = 0, bad = 0, cycles = 0, wr_cnt = 0, bus_err = 0;
  logic [31:0] mem [0:1023];

  lldma_channel u_dut (
    .clk(clk), .rst_n(rst_n),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
    .mem_bus(mem_bus), .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .preq_burst(preq_burst), .preq_single(preq_single),
    .preq_last_burst(preq_last_burst), .preq_last_single(preq_last_single),
    .preq_done(preq_done), .tc_irq(tc_irq)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      bad++;
      total++;
      $display("FAIL R4 watchdog: actual cycles=%0d expected below 150000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic bit lane_on(input logic [1:0] sz, input logic [1:0] off, input int b);
    case (sz)
      2'd0:    lane_on = (b == int'(off));
      2'd1:    lane_on = ((b >> 1) == int'(off[1]));
      default: lane_on = 1'b1;
    endcase
  endfunction

  // memory model: random acknowledge delay, byte lanes on write, fetch checks
  always @(negedge clk) begin
    if (!rst_n) mem_ack <= 1'b0;
    else if (mem_ack) mem_ack <= 1'b0;
    else if (mem_req && ($urandom_range(0, 3) != 0)) begin
      mem_ack <= 1'b1;
      if (mem_we) begin
        for (int b = 0; b < 4; b++)
          if (lane_on(mem_size, mem_addr[1:0], b)) mem[mem_addr[11:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
        wr_cnt <= wr_cnt + 1;
      end else begin
        mem_rdata <= mem[mem_addr[11:2]];
        if (mem_addr >= 32'h800 && mem_addr < 32'h900 &&
            (mem_bus != mem_addr[4] || mem_addr[1:0] != 2'b00)) bus_err <= bus_err + 1;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic rw(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rr(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 3000; i++) begin
      rr(3'd5, s);
      if (s[1:0] == 2'b00) break;
    end
  endtask

  // hold a request until serviced; n = elements written for it
  task automatic serve(input logic [3:0] kind, output int n);
    int start;
    @(negedge clk);
    start = wr_cnt;
    {preq_burst, preq_single, preq_last_burst, preq_last_single} = kind;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (preq_done) break;
    end
    {preq_burst, preq_single, preq_last_burst, preq_last_single} = 4'b0000;
    n = wr_cnt - start;
  endtask

  function automatic logic [31:0] mk_ctrl(input int cnt, input int sb, input int sw, input int dw,
                                          input bit si, input bit di, input bit ie);
    mk_ctrl = {ie, 3'b000, di, si, 2'b00, 3'(dw), 3'(sw), 3'd0, 3'(sb), 12'(cnt)};
  endfunction

  function automatic int exp_beats(input int rem, input int code);
    int len;
    len = (code == 0) ? 1 : (1 << (code + 1));
    exp_beats = (rem < len) ? rem : len;
  endfunction

  function automatic logic [7:0] byte_at(input int a);
    byte_at = mem[a >> 2][8*(a % 4) +: 8];
  endfunction

  task automatic fill(input int base, input int n, input int dbase);
    for (int i = 0; i < n; i++) begin
      mem[(base >> 2) + i]  = $urandom;
      mem[(dbase >> 2) + i] = 32'hDEAD0000 + i;
    end
  endtask

  task automatic load(input int s, input int d, input int nx, input logic [31:0] c);
    rw(3'd0, s); rw(3'd1, d); rw(3'd2, nx); rw(3'd3, c);
  endtask

  logic [31:0] v;
  int n, base0;

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    {preq_burst, preq_single, preq_last_burst, preq_last_single} = 4'b0000;
    for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rr(3'd5, v); chk("R1 status", v, 0);
    rr(3'd6, v); chk("R1 remaining", v, 0);
    chk("R1 tc_irq", {31'd0, tc_irq}, 0);
    chk("R1 mem_req", {31'd0, mem_req}, 0);

    // R3 R6 R10 R5 R4: controller mode, burst code 1, count 10
    fill(32'h100, 11, 32'h400);
    load(32'h100, 32'h400, 0, mk_ctrl(10, 1, 2, 2, 1, 1, 1));
    rw(3'd4, 32'h1);
    serve(4'b1000, n); chk("R6 first burst", n, exp_beats(10, 1));
    rr(3'd6, v); chk("R10 remaining after burst", v, 6);
    serve(4'b1000, n); chk("R6 second burst", n, exp_beats(6, 1));
    serve(4'b1000, n); chk("R6 shortened burst", n, exp_beats(2, 1));
    wait_idle();
    for (int i = 0; i < 10; i++) chk("R3 copied word", mem[32'h400/4 + i], mem[32'h100/4 + i]);
    chk("R3 no overrun", mem[32'h400/4 + 10], 32'hDEAD000A);
    rr(3'd5, v); chk("R4 idle status", {30'd0, v[1:0]}, 0);
    chk("R5 tc set", {31'd0, tc_irq}, 1);
    rw(3'd5, 32'h1);
    chk("R5 tc cleared", {31'd0, tc_irq}, 0);

    // R6 single requests with a long burst code; R5 no flag without enable
    fill(32'h180, 4, 32'h480);
    load(32'h180, 32'h480, 0, mk_ctrl(3, 7, 2, 2, 1, 1, 0));
    rw(3'd4, 32'h1);
    for (int k = 0; k < 3; k++) begin
      serve(4'b0100, n); chk("R6 single grant", n, 1);
    end
    wait_idle();
    chk("R5 no tc without enable", {31'd0, tc_irq}, 0);

    // R7 last inputs ignored in controller mode; R11 writes locked while active
    fill(32'h1C0, 4, 32'h4C0);
    load(32'h1C0, 32'h4C0, 0, mk_ctrl(3, 0, 2, 2, 1, 1, 0));
    rw(3'd4, 32'h1);
    n = wr_cnt;
    @(negedge clk); preq_last_burst = 1'b1;
    repeat (20) @(negedge clk);
    preq_last_burst = 1'b0; preq_last_single = 1'b1;
    repeat (20) @(negedge clk);
    preq_last_single = 1'b0;
    chk("R7 no writes on last inputs", wr_cnt - n, 0);
    rr(3'd6, v); chk("R7 remaining unchanged", v, 3);
    rw(3'd0, 32'h3F0);
    rr(3'd0, v); chk("R11 source locked", v, 32'h1C0);
    rw(3'd3, mk_ctrl(9, 0, 2, 2, 1, 1, 0));
    rr(3'd6, v); chk("R11 count locked", v, 3);
    rw(3'd4, 32'h0);
    rr(3'd5, v); chk("R11 enable locked", {31'd0, v[0]}, 1);
    for (int k = 0; k < 3; k++) serve(4'b0100, n);
    wait_idle();
    chk("R3 last word of run", mem[32'h4C0/4 + 2], mem[32'h1C0/4 + 2]);

    // R12 zero count
    n = wr_cnt;
    load(32'h100, 32'h400, 0, mk_ctrl(0, 0, 2, 2, 1, 1, 1));
    rw(3'd4, 32'h1);
    wait_idle();
    chk("R12 nothing moved", wr_cnt - n, 0);
    chk("R12 end handling sets tc", {31'd0, tc_irq}, 1);
    rw(3'd5, 32'h1);

    // R2 R3 R4 R5: random three-descriptor chains
    for (int r = 0; r < 3; r++) begin
      int cnt [3];
      int ptr [3];
      int sum;
      sum = 0;
      for (int i = 0; i < 3; i++) begin
        int b;
        cnt[i] = $urandom_range(1, 12);
        sum += cnt[i];
        b = 32'h800 + 16 * (i + 3 * r);
        ptr[i] = b | ((b >> 4) & 1);
        fill(32'h40 * i, 13, 32'h400 + 32'h40 * i);
      end
      for (int i = 1; i < 3; i++) begin
        int w;
        w = (ptr[i] & ~1) >> 2;
        mem[w]     = 32'h40 * i;
        mem[w + 1] = 32'h400 + 32'h40 * i;
        mem[w + 2] = (i == 2) ? 0 : ptr[i + 1];
        mem[w + 3] = mk_ctrl(cnt[i], $urandom_range(0, 3), 2, 2, 1, 1, i == 2);
      end
      load(0, 32'h400, ptr[1], mk_ctrl(cnt[0], $urandom_range(0, 3), 2, 2, 1, 1, 0));
      rw(3'd4, 32'h1);
      base0 = wr_cnt;
      for (int g = 0; g < 200 && (wr_cnt - base0) < sum; g++)
        serve(($urandom_range(0, 1) != 0) ? 4'b1000 : 4'b0100, n);
      wait_idle();
      chk("R3 chain element total", wr_cnt - base0, sum);
      for (int i = 0; i < 3; i++) begin
        for (int j = 0; j < cnt[i]; j++)
          chk("R2 chained copy", mem[(32'h400 + 32'h40 * i) / 4 + j], mem[(32'h40 * i) / 4 + j]);
        chk("R3 chain no overrun", mem[(32'h400 + 32'h40 * i) / 4 + cnt[i]], 32'hDEAD0000 + cnt[i]);
      end
      rr(3'd5, v); chk("R4 chain end idle", {30'd0, v[1:0]}, 0);
      chk("R5 tc on last descriptor", {31'd0, tc_irq}, 1);
      rw(3'd5, 32'h1);
    end
    chk("R2 fetch bus and alignment", bus_err, 0);

    // R8 peripheral mode: count 5 ignored, ends on last single
    fill(32'h200, 11, 32'h600);
    load(32'h200, 32'h600, 0, mk_ctrl(5, 1, 2, 2, 1, 1, 1));
    rw(3'd4, 32'h3);
    base0 = wr_cnt;
    serve(4'b1000, n); chk("R8 burst grant", n, 4);
    serve(4'b0100, n); chk("R8 single grant", n, 1);
    serve(4'b1000, n); chk("R8 burst past count", n, 4);
    serve(4'b0001, n); chk("R8 last single grant", n, 1);
    wait_idle();
    chk("R8 total elements", wr_cnt - base0, 10);
    for (int i = 0; i < 10; i++) chk("R8 copied word", mem[32'h600/4 + i], mem[32'h200/4 + i]);
    chk("R8 no extra word", mem[32'h600/4 + 10], 32'hDEAD000A);
    rr(3'd6, v); chk("R10 remaining saturates", v, 0);
    rw(3'd5, 32'h1);

    // R8 last burst ends a zero-count descriptor in peripheral mode
    load(32'h200, 32'h640, 0, mk_ctrl(0, 1, 2, 2, 1, 1, 0));
    rw(3'd4, 32'h3);
    serve(4'b0010, n); chk("R8 last burst grant", n, 4);
    wait_idle();
    rr(3'd5, v); chk("R8 idle after last", {30'd0, v[1:0]}, 0);

    // R9 fixed destination
    fill(32'h280, 6, 32'h680);
    load(32'h280, 32'h680, 0, mk_ctrl(5, 0, 2, 2, 1, 0, 0));
    rw(3'd4, 32'h1);
    for (int k = 0; k < 5; k++) serve(4'b0100, n);
    wait_idle();
    chk("R9 fixed dst holds last", mem[32'h680/4], mem[32'h280/4 + 4]);
    chk("R9 fixed dst neighbour", mem[32'h680/4 + 1], 32'hDEAD0001);

    // R9 fixed source
    fill(32'h2C0, 4, 32'h6C0);
    load(32'h2C0, 32'h6C0, 0, mk_ctrl(3, 1, 2, 2, 0, 1, 0));
    rw(3'd4, 32'h1);
    serve(4'b1000, n);
    wait_idle();
    for (int i = 0; i < 3; i++) chk("R9 fixed src repeats", mem[32'h6C0/4 + i], mem[32'h2C0/4]);

    // R9 byte elements
    fill(32'h300, 3, 32'h700);
    load(32'h301, 32'h701, 0, mk_ctrl(6, 1, 0, 0, 1, 1, 0));
    rw(3'd4, 32'h1);
    serve(4'b1000, n); chk("R9 byte burst", n, 4);
    serve(4'b1000, n); chk("R9 byte short burst", n, 2);
    wait_idle();
    for (int i = 0; i < 6; i++) chk("R9 byte copy", {24'd0, byte_at(32'h701 + i)}, {24'd0, byte_at(32'h301 + i)});
    chk("R9 byte below untouched", {24'd0, byte_at(32'h700)}, 32'h00);
    chk("R9 byte above untouched", {24'd0, byte_at(32'h707)}, 32'hDE);
    rr(3'd1, v); chk("R9 byte dst address", v, 32'h707);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule